// File: doc/BRIEF.md
# Scrolling Hex Digit Display Driver

This block drives a row of four seven-segment displays whose segment lines are wired in common. All displays receive the same segment pattern, so any display that is switched on shows the same hexadecimal character. The sense of motion comes from switching on one display at a time and walking that single enable from the leftmost position to the rightmost. The block does not multiplex different digits.

A free-running divider counter runs on the fast board clock, which is 50 MHz by default. Divider bit n toggles at the clock rate divided by 2^(n+1). The rising edge of one chosen bit is detected in the clock domain and used as a step enable. No divider bit is ever used as a clock. The default bit is 24, which gives a step rate of about 1.5 Hz. The shown digit advances by one each time the lit position wraps from the right end back to the left end.

The position walk is an explicit state machine with four states: `POS_LEFT`, `POS_MID_L`, `POS_MID_R` and `POS_RIGHT`. On a step enable it makes these transitions:
- `POS_LEFT` to `POS_MID_L`
- `POS_MID_L` to `POS_MID_R`
- `POS_MID_R` to `POS_RIGHT`
- `POS_RIGHT` to `POS_LEFT`, named the wrap transition, which also advances the digit

Without a step enable, every state holds.

Top module: `hex_scroll_display`

## Requirements
- R1: While reset is high, and after it is released until the first step, the shown digit is 0 and the enables are `an_n = 4'b0111`.
- R2: Enables are active low and `an_n[3]` is the leftmost display. Exactly one bit of `an_n` is 0 at all times.
- R3: Each step moves the lit position one place to the right. The enable sequence is 0111, 1011, 1101, 1110, and then it repeats from 0111.
- R4: A step happens on the clock edge after the divider bit `TICK_BIT` rises. With H = 2^TICK_BIT, the first step completes on the (H+1)-th rising clock edge after reset release. Further steps follow every 2H edges.
- R5: The digit increases by one on the wrap step only. Between wraps, `seg_n` holds steady.
- R6: After F the digit returns to 0.
- R7: Segments are active low, with `seg_n` = {g,f,e,d,c,b,a}. The lit patterns, written active high for digits 0 to F, are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. These give distinct glyphs A, b, C, d, E and F.
- R8: Reset is asynchronous. Raising it in the middle of a run restores the R1 outputs without any clock edge. Counting then restarts under the R4 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast board clock; all logic is on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| seg_n | output | 7 | Shared segment lines {g,f,e,d,c,b,a}, active low |
| an_n | output | 4 | Display enables, active low, bit 3 is leftmost |

## Verification
The bench shortens the divider so that many full scrolls fit in a short run. It compares every cycle against a count-derived model, which catches an off-by-one edge detector that steps one cycle early or late, or one that steps on both edges of the divider bit. It runs through all sixteen digits and past the F-to-0 wrap. This exposes a digit that advances on every step instead of only on the wrap, a wrong glyph, and a right-to-left walk. A reset pulse raised between clock edges mid-scroll shows whether the reset is really asynchronous and whether the divider restarts, rather than carrying a stale phase into the next step.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

    typedef enum logic [1:0] {
        POS_LEFT  = 2'd0,
        POS_MID_L = 2'd1,
        POS_MID_R = 2'd2,
        POS_RIGHT = 2'd3
    } pos_t;

    localparam int NUM_POS   = 4;
    localparam int SEG_LINES = 7;
    localparam int HEX_W     = 4;

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int DIV_WIDTH = 25,
    parameter int TICK_BIT  = 24
) (
    input  logic clk,
    input  logic rst,
    output logic step_en
);
    logic [DIV_WIDTH-1:0] div_cnt;
    logic                 tap_prev;

    generate
        if (TICK_BIT >= DIV_WIDTH) begin : g_bad_tap
            initial $error("rate_divider: TICK_BIT must be below DIV_WIDTH");
        end
    endgenerate

    // free-running divider
    always_ff @(posedge clk or posedge rst) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    // one-cycle enable on the rising edge of the chosen bit
    always_ff @(posedge clk or posedge rst) begin
        if (rst) tap_prev <= 1'b0;
        else     tap_prev <= div_cnt[TICK_BIT];
    end

    assign step_en = div_cnt[TICK_BIT] & ~tap_prev;

endmodule

// File: rtl/scroll_fsm.sv
module scroll_fsm
    import scroll_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    output logic [NUM_POS-1:0] an_n,
    output logic               wrap
);
    pos_t state_q, state_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= POS_LEFT;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (step_en) begin
            unique case (state_q)
                POS_LEFT:  state_d = POS_MID_L;
                POS_MID_L: state_d = POS_MID_R;
                POS_MID_R: state_d = POS_RIGHT;
                POS_RIGHT: state_d = POS_LEFT;
                default:   state_d = POS_LEFT;
            endcase
        end
    end

    // outputs: one active-low enable, bit 3 leftmost
    always_comb begin
        wrap = 1'b0;
        unique case (state_q)
            POS_LEFT:  an_n = 4'b0111;
            POS_MID_L: an_n = 4'b1011;
            POS_MID_R: an_n = 4'b1101;
            POS_RIGHT: begin
                an_n = 4'b1110;
                wrap = step_en;
            end
            default:   an_n = 4'b0111;
        endcase
    end

endmodule

// File: rtl/hex_digit_reg.sv
module hex_digit_reg
    import scroll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [HEX_W-1:0] digit
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)          digit <= '0;
        else if (advance) digit <= digit + 1'b1;  // F rolls to 0
    end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
    import scroll_pkg::*;
(
    input  logic [HEX_W-1:0]     digit,
    output logic [SEG_LINES-1:0] seg_n
);
    logic [SEG_LINES-1:0] lit;  // {g,f,e,d,c,b,a}, 1 = on

    always_comb begin
        unique case (digit)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            4'hF: lit = 7'h71;
            default: lit = 7'h3F;
        endcase
    end

    assign seg_n = ~lit;
endmodule

// File: rtl/hex_scroll_display.sv
module hex_scroll_display
    import scroll_pkg::*;
#(
    parameter int DIV_WIDTH = 25,
    parameter int TICK_BIT  = 24
) (
    input  logic       clk,
    input  logic       rst,
    output logic [6:0] seg_n,
    output logic [3:0] an_n
);
    logic             step_en;
    logic             wrap;
    logic [HEX_W-1:0] digit;

    rate_divider #(
        .DIV_WIDTH (DIV_WIDTH),
        .TICK_BIT  (TICK_BIT)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en)
    );

    scroll_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .an_n    (an_n),
        .wrap    (wrap)
    );

    hex_digit_reg u_digit (
        .clk     (clk),
        .rst     (rst),
        .advance (wrap),
        .digit   (digit)
    );

    seg_decoder u_dec (
        .digit (digit),
        .seg_n (seg_n)
    );

endmodule

// File: rtl/hex_scroll_checker.sv
module hex_scroll_checker (
    input logic       clk,
    input logic       rst,
    input logic [6:0] seg_n,
    input logic [3:0] an_n
);
    logic [3:0] an_prev;
    logic [6:0] seg_prev;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            an_prev  <= 4'b0111;
            seg_prev <= 7'h40;
        end else begin
            an_prev  <= an_n;
            seg_prev <= seg_n;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            assert_reset_state_R1 : assert (an_n == 4'b0111 && seg_n == 7'h40)
                else $error("reset outputs wrong");
        end
    end

    assert_one_enable_R2 : assert property (@(posedge clk) disable iff (rst)
        $countones(~an_n) == 1);

    assert_walk_order_R3 : assert property (@(posedge clk) disable iff (rst)
        (an_n != an_prev) |-> (an_n == {an_prev[0], an_prev[3:1]}));

    assert_digit_on_wrap_R5 : assert property (@(posedge clk) disable iff (rst)
        (seg_n != seg_prev) |-> (an_prev == 4'b1110 && an_n == 4'b0111));

    assert_some_segment_lit_R7 : assert property (@(posedge clk) disable iff (rst)
        seg_n != 7'h7F);

endmodule

bind hex_scroll_display hex_scroll_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .seg_n (seg_n),
    .an_n  (an_n)
);

// File: tb/sim_hex_scroll_display.sv
`timescale 1ns/1ps
module sim_hex_scroll_display;
    localparam int TB_DIV  = 6;
    localparam int TB_TICK = 2;
    localparam int HALF    = 1 << TB_TICK;
    localparam int PER     = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] seg_n;
    logic [3:0] an_n;
    int         checks = 0;
    int         failures = 0;
    int         since_rel = 0;

    hex_scroll_display #(.DIV_WIDTH(TB_DIV), .TICK_BIT(TB_TICK)) u0 (
        .clk(clk), .rst(rst), .seg_n(seg_n), .an_n(an_n)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk or posedge rst) begin
        if (rst) since_rel <= 0;
        else     since_rel <= since_rel + 1;
    end

    function automatic logic [6:0] glyph_n(input int d);
        logic [6:0] on;
        case (d & 15)
            0: on = 7'h3F;  1: on = 7'h06;  2: on = 7'h5B;  3: on = 7'h4F;
            4: on = 7'h66;  5: on = 7'h6D;  6: on = 7'h7D;  7: on = 7'h07;
            8: on = 7'h7F;  9: on = 7'h6F; 10: on = 7'h77; 11: on = 7'h7C;
            12: on = 7'h39; 13: on = 7'h5E; 14: on = 7'h79; default: on = 7'h71;
        endcase
        return ~on;
    endfunction

    function automatic int steps_after(input int n);
        if (n < HALF + 1) return 0;
        return (n - HALF - 1) / PER + 1;
    endfunction

    function automatic logic [3:0] enable_n(input int pos);
        return ~(4'b1000 >> (pos % 4));
    endfunction

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (t=%0t edges=%0d)", req, act, exp, $time, since_rel);
        end
    endtask

    task automatic check_model(input string req);
        int s;
        s = steps_after(since_rel);
        check(req, {seg_n, an_n}, {glyph_n(s / 4), enable_n(s)});
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to(input int n);
        while (since_rel < n) @(negedge clk);
    endtask

    // R1: reset state held and kept until the first step
    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 during reset", {seg_n, an_n}, {7'h40, 4'b0111});
        release_reset();
        run_to(HALF);
        check("R1 before first step", {seg_n, an_n}, {7'h40, 4'b0111});
    endtask

    // R4: first step lands on edge H+1, the next one 2H later
    task automatic t_first_step();
        run_to(HALF + 1);
        check("R4 first step", {7'h0, an_n}, {7'h0, 4'b1011});
        run_to(HALF + PER);
        check("R4 hold before second step", {7'h0, an_n}, {7'h0, 4'b1011});
        run_to(HALF + PER + 1);
        check("R4 second step", {7'h0, an_n}, {7'h0, 4'b1101});
    endtask

    // R2 R3 R5 R6 R7: compare every cycle over more than sixteen full scrolls
    task automatic t_digit_run();
        int last = HALF + 1 + PER * 68;
        while (since_rel < last) begin
            @(negedge clk);
            check_model("R3/R5/R6/R7 model");
            check("R2 one enable", 11'($countones(~an_n)), 11'd1);
        end
        check("R6 wrapped back to 0", {seg_n, 4'h0}, {glyph_n(1), 4'h0});
    endtask

    // R8: asynchronous reset mid-run, then R4 timing again
    task automatic t_async_reset();
        run_to(since_rel + PER * 2 + 3);
        @(posedge clk);
        #1 rst = 1'b1;
        #0.5;
        check("R8 async reset outputs", {seg_n, an_n}, {7'h40, 4'b0111});
        release_reset();
        run_to(HALF);
        check("R8 restart hold", {seg_n, an_n}, {7'h40, 4'b0111});
        run_to(HALF + 1);
        check("R8 restart step", {seg_n, an_n}, {7'h40, 4'b1011});
    endtask

    initial begin
        t_reset_state();
        t_first_step();
        t_digit_run();
        t_async_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule